// File: doc/BRIEF.md
# DMA Channel Register Front-End with Aliased Windows

This block is the programming interface and sequencing core of one DMA channel. Software sees four channel registers: a read pointer, a write pointer, a transfer count and a control word. They are reached through four 16-byte windows. Each window lists the same four registers in a different order. The word at offset 0xC of every window is a trigger. A nonzero write there stores the value and also launches the channel. One bus write can therefore load the last missing parameter and start the job.

Once started, the channel copies data one transfer at a time. It issues a read request, waits for the read handshake and captures the data. It then issues a write request carrying that data and waits for the write handshake. After each completed read the read pointer steps by the transfer size, and after each completed write the write pointer does the same, when the matching increment enable is set. The transfer count counts bus transfers, not bytes. When the working counter runs out, the channel drops busy and waits for the next trigger.

Top module: `dma_alias_channel`

## Requirements
- R1: Register bus address bits [5:4] select the window and bits [3:2] select the word. Window 0 holds read pointer, write pointer, count and control. Window 1 holds control, read pointer, write pointer and count. Window 2 holds control, count, read pointer and write pointer. Window 3 holds control, write pointer, count and read pointer. All four windows reach the same storage.
- R2: Control word fields are: bit 0 enable, bits [3:2] size, bit 4 read-increment enable and bit 5 write-increment enable. Every other bit reads as 0, except bit 24, which reads the busy flag and cannot be written.
- R3: A write to word 3 of any window with nonzero data stores the value. If the resulting enable bit is 1 and the resulting count is nonzero, it loads the working counter from the count and raises busy on the same clock edge. If enable is 0, busy stays low.
- R4: A write to word 0, 1 or 2 of any window, or a write of zero to word 3, only updates the addressed register and never raises busy.
- R5: While busy is high, register bus writes are ignored and the pointers change only on completed handshakes.
- R6: Each transfer is one read handshake followed by one write handshake. A request stays valid with a stable address until ready is seen. The read and write requests are never valid together. The write data equals the data captured at the read handshake.
- R7: The read request address is the read pointer, and the write request address is the write pointer. Each pointer advances by the step after its handshake when its increment enable is 1, and holds otherwise. The step is 1 for size 00, 2 for size 01 and 4 for sizes 10 and 11.
- R8: The working counter decrements at each write handshake, and busy falls right after the handshake that takes it to zero. While busy, the count word reads the remaining count. While idle, it reads the programmed count, so a new trigger reloads the full count.
- R9: After reset all registers read 0, busy is low and neither request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address (window, word) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| busy | output | 1 | Channel running |
| mrd_valid | output | 1 | Read request valid |
| mrd_addr | output | 32 | Read request address |
| mrd_ready | input | 1 | Read handshake ready |
| mrd_data | input | 32 | Read data, taken at the read handshake |
| mwr_valid | output | 1 | Write request valid |
| mwr_addr | output | 32 | Write request address |
| mwr_data | output | 32 | Write request data |
| mwr_ready | input | 1 | Write handshake ready |

## Verification
A window mapping error shows up on the first readback through another window, one clock after the write. A wrong pointer or step shows in the address of the very next handshake. A wrong working count shows when busy falls one transfer early or late, or when the live count word is read mid-job. A lost captured word appears as wrong write data on the write handshake that follows its read.

// File: rtl/dma_alias_pkg.sv
package dma_alias_pkg;

  typedef enum logic [1:0] {
    SEL_RPTR  = 2'd0,
    SEL_WPTR  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_SIZE_LO  = 2;
  localparam int CTL_INCR_RD  = 4;
  localparam int CTL_INCR_WR  = 5;
  localparam int CTL_BUSY_BIT = 24;
  localparam logic [31:0] CTL_WMASK = 32'h0000_003D;

  // window number and word index to the register it exposes
  function automatic reg_sel_e window_map(input logic [1:0] win, input logic [1:0] word);
    reg_sel_e s;
    unique case (win)
      2'd0: case (word)
              2'd0: s = SEL_RPTR;
              2'd1: s = SEL_WPTR;
              2'd2: s = SEL_COUNT;
              default: s = SEL_CTRL;
            endcase
      2'd1: case (word)
              2'd0: s = SEL_CTRL;
              2'd1: s = SEL_RPTR;
              2'd2: s = SEL_WPTR;
              default: s = SEL_COUNT;
            endcase
      2'd2: case (word)
              2'd0: s = SEL_CTRL;
              2'd1: s = SEL_COUNT;
              2'd2: s = SEL_RPTR;
              default: s = SEL_WPTR;
            endcase
      default: case (word)
              2'd0: s = SEL_CTRL;
              2'd1: s = SEL_WPTR;
              2'd2: s = SEL_COUNT;
              default: s = SEL_RPTR;
            endcase
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dma_alias_decode.sv
module dma_alias_decode
  import dma_alias_pkg::*;
#(
  parameter int BUS_AW = 6
) (
  input  logic [BUS_AW-1:0] addr,
  output reg_sel_e          sel,
  output logic              is_trig
);
  localparam logic [1:0] TRIG_WORD = 2'd3;

  logic [1:0] win;
  logic [1:0] word;

  always_comb begin
    win     = addr[5:4];
    word    = addr[3:2];
    sel     = window_map(win, word);
    is_trig = (word == TRIG_WORD);
  end
endmodule

// File: rtl/dma_alias_regs.sv
module dma_alias_regs
  import dma_alias_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic              is_trig,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rd_adv,
  input  logic              wr_adv,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] rptr,
  output logic [ADDR_W-1:0] wptr,
  output logic [CNT_W-1:0]  cnt_prog,
  output logic [REG_W-1:0]  ctrl,
  output logic              start,
  output logic [CNT_W-1:0]  start_count
);
  logic [ADDR_W-1:0] rptr_n, wptr_n;
  logic [CNT_W-1:0]  cnt_n;
  logic [REG_W-1:0]  ctrl_n;
  logic              rptr_en, wptr_en, cnt_en, ctrl_en;

  always_comb begin
    rptr_n  = rptr;
    wptr_n  = wptr;
    cnt_n   = cnt_prog;
    ctrl_n  = ctrl;
    rptr_en = 1'b0;
    wptr_en = 1'b0;
    cnt_en  = 1'b0;
    ctrl_en = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_RPTR:  begin rptr_n = wdata[ADDR_W-1:0]; rptr_en = 1'b1; end
        SEL_WPTR:  begin wptr_n = wdata[ADDR_W-1:0]; wptr_en = 1'b1; end
        SEL_COUNT: begin cnt_n  = wdata[CNT_W-1:0];  cnt_en  = 1'b1; end
        default:   begin ctrl_n = wdata & CTL_WMASK; ctrl_en = 1'b1; end
      endcase
    end
    if (rd_adv) begin
      rptr_n  = rptr + step;
      rptr_en = 1'b1;
    end
    if (wr_adv) begin
      wptr_n  = wptr + step;
      wptr_en = 1'b1;
    end
    start_count = cnt_n;
    start = wr_en && is_trig && (wdata != '0) && ctrl_n[CTL_EN_BIT] && (cnt_n != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      wptr     <= '0;
      cnt_prog <= '0;
      ctrl     <= '0;
    end else begin
      if (rptr_en) rptr     <= rptr_n;
      if (wptr_en) wptr     <= wptr_n;
      if (cnt_en)  cnt_prog <= cnt_n;
      if (ctrl_en) ctrl     <= ctrl_n;
    end
  end
endmodule

// File: rtl/dma_alias_engine.sv
module dma_alias_engine
  import dma_alias_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [1:0]        size,
  input  logic              incr_rd,
  input  logic              incr_wr,
  input  logic [ADDR_W-1:0] rptr,
  input  logic [ADDR_W-1:0] wptr,
  input  logic              mrd_ready,
  input  logic [DATA_W-1:0] mrd_data,
  input  logic              mwr_ready,
  output logic              busy,
  output logic              mrd_valid,
  output logic [ADDR_W-1:0] mrd_addr,
  output logic              mwr_valid,
  output logic [ADDR_W-1:0] mwr_addr,
  output logic [DATA_W-1:0] mwr_data,
  output logic              rd_adv,
  output logic              wr_adv,
  output logic [ADDR_W-1:0] step,
  output logic [CNT_W-1:0]  cnt_work
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  eng_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              cnt_en, data_en;
  logic              rd_hs, wr_hs;

  always_comb begin
    unique case (size)
      2'b00:   step = ADDR_W'(1);
      2'b01:   step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_work;
    data_n  = data_q;
    cnt_en  = 1'b0;
    data_en = 1'b0;
    rd_hs   = (state_q == ST_READ) && mrd_ready;
    wr_hs   = (state_q == ST_WRITE) && mwr_ready;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_READ;
          cnt_n   = start_count;
          cnt_en  = 1'b1;
        end
      end
      ST_READ: begin
        if (mrd_ready) begin
          data_n  = mrd_data;
          data_en = 1'b1;
          state_n = ST_WRITE;
        end
      end
      default: begin
        if (mwr_ready) begin
          cnt_n   = cnt_work - CNT_ONE;
          cnt_en  = 1'b1;
          state_n = (cnt_work == CNT_ONE) ? ST_IDLE : ST_READ;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_work <= '0;
      data_q   <= '0;
    end else begin
      state_q <= state_n;
      if (cnt_en)  cnt_work <= cnt_n;
      if (data_en) data_q   <= data_n;
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    mrd_valid = (state_q == ST_READ);
    mwr_valid = (state_q == ST_WRITE);
    mrd_addr  = rptr;
    mwr_addr  = wptr;
    mwr_data  = data_q;
    rd_adv    = rd_hs && incr_rd;
    wr_adv    = wr_hs && incr_wr;
  end
endmodule

// File: rtl/dma_alias_channel.sv
module dma_alias_channel
  import dma_alias_pkg::*;
#(
  parameter int BUS_AW = 6,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              busy,
  output logic              mrd_valid,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrd_ready,
  input  logic [DATA_W-1:0] mrd_data,
  output logic              mwr_valid,
  output logic [ADDR_W-1:0] mwr_addr,
  output logic [DATA_W-1:0] mwr_data,
  input  logic              mwr_ready
);
  reg_sel_e          sel;
  logic              is_trig;
  logic              wr_en;
  logic [ADDR_W-1:0] rptr, wptr, step;
  logic [CNT_W-1:0]  cnt_prog, cnt_work, start_count;
  logic [REG_W-1:0]  ctrl;
  logic              start, rd_adv, wr_adv;

  dma_alias_decode #(.BUS_AW(BUS_AW)) u_decode (
    .addr    (bus_addr),
    .sel     (sel),
    .is_trig (is_trig)
  );

  assign wr_en = bus_wr && !busy;

  dma_alias_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .sel         (sel),
    .is_trig     (is_trig),
    .wdata       (bus_wdata),
    .rd_adv      (rd_adv),
    .wr_adv      (wr_adv),
    .step        (step),
    .rptr        (rptr),
    .wptr        (wptr),
    .cnt_prog    (cnt_prog),
    .ctrl        (ctrl),
    .start       (start),
    .start_count (start_count)
  );

  dma_alias_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_count (start_count),
    .size        (ctrl[CTL_SIZE_LO+1:CTL_SIZE_LO]),
    .incr_rd     (ctrl[CTL_INCR_RD]),
    .incr_wr     (ctrl[CTL_INCR_WR]),
    .rptr        (rptr),
    .wptr        (wptr),
    .mrd_ready   (mrd_ready),
    .mrd_data    (mrd_data),
    .mwr_ready   (mwr_ready),
    .busy        (busy),
    .mrd_valid   (mrd_valid),
    .mrd_addr    (mrd_addr),
    .mwr_valid   (mwr_valid),
    .mwr_addr    (mwr_addr),
    .mwr_data    (mwr_data),
    .rd_adv      (rd_adv),
    .wr_adv      (wr_adv),
    .step        (step),
    .cnt_work    (cnt_work)
  );

  always_comb begin
    unique case (sel)
      SEL_RPTR:  bus_rdata = REG_W'(rptr);
      SEL_WPTR:  bus_rdata = REG_W'(wptr);
      SEL_COUNT: bus_rdata = REG_W'(busy ? cnt_work : cnt_prog);
      default: begin
        bus_rdata = ctrl;
        bus_rdata[CTL_BUSY_BIT] = busy;
      end
    endcase
  end
endmodule

// File: rtl/dma_alias_channel_chk.sv
module dma_alias_channel_chk #(
  parameter int BUS_AW = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              busy,
  input logic              mrd_valid,
  input logic [ADDR_W-1:0] mrd_addr,
  input logic              mrd_ready,
  input logic [DATA_W-1:0] mrd_data,
  input logic              mwr_valid,
  input logic [ADDR_W-1:0] mwr_addr,
  input logic [DATA_W-1:0] mwr_data,
  input logic              mwr_ready
);
  // R6
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mrd_valid, mwr_valid}));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && mrd_ready) |=> (mwr_valid && (mwr_data == $past(mrd_data))));

  // R8
  end_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mwr_valid && mwr_ready));

  // R4
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr && (bus_addr[3:2] != 2'b11)) |=> !busy);

  // R5
  frozen_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(mrd_valid && mrd_ready) && !(mwr_valid && mwr_ready))
      |=> ($stable(mrd_addr) && $stable(mwr_addr)));
endmodule

bind dma_alias_channel dma_alias_channel_chk #(
  .BUS_AW(BUS_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/dma_alias_channel_bench.sv
`timescale 1ns/1ps
module dma_alias_channel_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        busy;
  logic        mrd_valid, mrd_ready, mwr_valid, mwr_ready;
  logic [31:0] mrd_addr, mrd_data, mwr_addr, mwr_data;

  int errors = 0;
  int checks = 0;

  // responder model state
  int          allow;
  logic [31:0] exp_r, exp_w, saved, stepv;
  bit          inc_r, inc_w;
  int          hs_rd, hs_wr;

  dma_alias_channel u_dma_alias_channel (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0000_1234;
  endfunction

  // register codes: 0 read ptr, 1 write ptr, 2 count, 3 control
  function automatic int reg_at(input int win, input int word);
    int t[4][4] = '{'{0,1,2,3}, '{3,0,1,2}, '{3,2,0,1}, '{3,1,2,0}};
    return t[win][word];
  endfunction

  function automatic int word_of(input int win, input int r);
    for (int k = 0; k < 4; k++) if (reg_at(win, k) == r) return k;
    return 0;
  endfunction

  function automatic logic [31:0] step_of(input logic [1:0] sz);
    return (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int win, input int word, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = 6'(win * 16 + word * 4);
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int win, input int word, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(win * 16 + word * 4);
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, req, 32'(busy), 32'd0);
  endtask

  // memory side responder, decides ready at each falling edge
  always @(negedge clk) begin
    bit rr, rw;
    if (rst_n) begin
      rr = (allow != 0) && ($urandom % 4 != 0);
      rw = (allow != 0) && ($urandom % 4 != 0);
      if (mrd_valid && rr) begin
        check(mrd_addr == exp_r, "R7 read address", mrd_addr, exp_r);
        saved = mem(mrd_addr);
        if (inc_r) exp_r = exp_r + stepv;
        hs_rd++;
        if (allow > 0) allow--;
      end
      if (mwr_valid && rw) begin
        check(mwr_addr == exp_w, "R7 write address", mwr_addr, exp_w);
        check(mwr_data == saved, "R6 write data", mwr_data, saved);
        if (inc_w) exp_w = exp_w + stepv;
        hs_wr++;
        if (allow > 0) allow--;
      end
      mrd_ready = rr;
      mwr_ready = rw;
      mrd_data  = mem(mrd_addr);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] vals[4];
    process::self().srandom(32'd20240611);
    allow = 0; hs_rd = 0; hs_wr = 0;
    exp_r = 0; exp_w = 0; saved = 0; stepv = 1; inc_r = 0; inc_w = 0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    mrd_ready = 0; mwr_ready = 0; mrd_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9 reset state
    for (int w = 0; w < 4; w++) begin
      rd(w, w, d);
      check(d == 32'd0, "R9 reset readback", d, 32'd0);
    end
    check({busy, mrd_valid, mwr_valid} == 3'b000, "R9 idle outputs", 32'({busy, mrd_valid, mwr_valid}), 32'd0);

    // R1 layout, control trigger with enable clear must not start (R3)
    vals[0] = 32'h1111_0000; vals[1] = 32'h2222_0000; vals[2] = 32'd5; vals[3] = 32'h30;
    wr(0, 0, vals[0]);
    wr(0, 1, vals[1]);
    wr(0, 2, vals[2]);
    wr(0, 3, vals[3]);
    check(!busy, "R3 disabled trigger no start", 32'(busy), 32'd0);
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 4; k++) begin
        rd(w, k, d);
        check(d == vals[reg_at(w, k)], "R1 window layout", d, vals[reg_at(w, k)]);
      end

    // R2 control mask and read-only busy bit
    wr(1, 0, 32'hFFFF_FFFE);
    rd(3, 0, d);
    check(d == 32'h0000_003C, "R2 control mask", d, 32'h3C);

    // R4 zero trigger and non-trigger writes
    wr(1, 0, 32'h1);
    check(!busy, "R4 non-trigger control write", 32'(busy), 32'd0);
    wr(2, 1, 32'd7);
    check(!busy, "R4 non-trigger count write", 32'(busy), 32'd0);
    wr(2, 3, 32'd0);
    check(!busy, "R4 zero trigger", 32'(busy), 32'd0);
    rd(0, 1, d);
    check(d == 32'd0, "R4 zero trigger stores", d, 32'd0);
    wr(1, 3, 32'd0);
    check(!busy, "R4 zero count trigger", 32'(busy), 32'd0);

    // R5 R8 live count with held handshakes
    wr(0, 0, 32'h0000_4000);
    exp_r = 32'h0000_4000; exp_w = 32'd0; inc_r = 0; inc_w = 0; stepv = 1;
    hs_rd = 0; hs_wr = 0; allow = 0;
    wr(1, 3, 32'd3);
    check(busy, "R3 count trigger starts", 32'(busy), 32'd1);
    rd(2, 1, d);
    check(d == 32'd3, "R8 live count at start", d, 32'd3);
    rd(1, 0, d);
    check(d == 32'h0100_0001, "R2 busy bit reads", d, 32'h0100_0001);
    wr(0, 0, 32'h0000_9999);
    rd(3, 3, d);
    check(d == 32'h0000_4000, "R5 write ignored while busy", d, 32'h4000);
    allow = 2;
    while (hs_wr < 1) @(negedge clk);
    rd(0, 2, d);
    check(d == 32'd2, "R8 live count after one transfer", d, 32'd2);
    allow = -1;
    wait_idle("R8 busy clears");
    check(hs_wr == 3, "R8 transfer total", 32'(hs_wr), 32'd3);
    rd(0, 2, d);
    check(d == 32'd3, "R8 programmed count when idle", d, 32'd3);

    // random jobs through every window trigger
    for (int it = 0; it < 40; it++) begin
      int win, trig;
      logic [1:0] sz;
      bit ir, iw;
      logic [31:0] ra, wa, ct, n;
      win = it % 4;
      sz = 2'($urandom % 4);
      ir = 1'($urandom % 2);
      iw = 1'($urandom % 2);
      n  = 32'(1 + $urandom % 6);
      ra = $urandom | 32'h1000;
      wa = $urandom | 32'h1000;
      ct = 32'h1 | (32'(sz) << 2) | (32'(ir) << 4) | (32'(iw) << 5);
      vals[0] = ra; vals[1] = wa; vals[2] = n; vals[3] = ct;
      trig = reg_at(win, 3);
      for (int r = 0; r < 4; r++)
        if (r != trig) wr(win, word_of(win, r), vals[r]);
      exp_r = ra; exp_w = wa; inc_r = ir; inc_w = iw; stepv = step_of(sz);
      hs_rd = 0; hs_wr = 0;
      wr(win, 3, vals[trig]);
      check(busy, "R3 trigger starts", 32'(busy), 32'd1);
      wait_idle("R8 job ends");
      check(hs_wr == int'(n), "R8 transfer count", 32'(hs_wr), n);
      check(hs_rd == int'(n), "R6 read per transfer", 32'(hs_rd), n);
      rd((win + 1) % 4, word_of((win + 1) % 4, 0), d);
      check(d == exp_r, "R7 final read pointer", d, exp_r);
      rd((win + 2) % 4, word_of((win + 2) % 4, 1), d);
      check(d == exp_w, "R7 final write pointer", d, exp_w);
      rd((win + 3) % 4, word_of((win + 3) % 4, 2), d);
      check(d == n, "R8 count after job", d, n);
      rd(win, word_of(win, 3), d);
      check(d == ct, "R2 control after job", d, ct);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule